// File: doc/BRIEF.md
# Load Address Generator

This block forms the effective address for fixed-point loads on a 64-bit datapath. Each cycle it may accept one request. A request carries the two source register values, the base and target register numbers, a two-bit addressing form, an update flag and the raw 16-bit immediate field. The block adds an offset to a base to produce the address. The offset is a scaled, sign-extended immediate or the second register value, depending on the form. The base is either the first register value or zero.

For update forms the block also produces a write-back request that puts the address into the base register. A base register number of zero, or a base register number equal to the target, makes an update request an invalid form. Such a request is flagged, and its write-back is withheld. The result leaves through one output register, so the address, write-back and invalid flag all appear one clock after the request. The add wraps at 64 bits and reports no carry.

Top module: `lea_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid`, `wb_en` and `bad_form` are 0.
- R2: For a request with `upd`=0, the base is `ra_val` when `ra_idx` is nonzero. When `ra_idx` is 0, the base is zero whatever `ra_val` holds.
- R3: With `form`=0 (displacement), the offset is `imm[15:0]` sign-extended to 64 bits.
- R4: With `form`=1 (word-scaled), the offset is `imm[15:2]` with two zero bits appended below it, sign-extended from bit 15.
- R5: With `form`=2 (quad-scaled), the offset is `imm[15:4]` with four zero bits appended below it, sign-extended from bit 15.
- R6: With `form`=3 (indexed), the offset is `rb_val`, and `imm` has no effect on `ea`.
- R7: For a request with `upd`=1, the base is `ra_val` even when `ra_idx` is 0. If the form is valid, `wb_en` is 1 and `wb_val` equals `ea`.
- R8: A request with `upd`=1 and either `ra_idx`=0 or `ra_idx`=`rt_idx` raises `bad_form` for that one output cycle and holds `wb_en` at 0. `ea` is still produced.
- R9: The addition is taken modulo 2^64.
- R10: Each request appears on the outputs exactly one clock after it is accepted with `out_valid`=1. Without a request, `out_valid`, `wb_en` and `bad_form` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| ra_val | input | 64 | Contents of the base register |
| rb_val | input | 64 | Contents of the index register |
| ra_idx | input | 5 | Base register number |
| rt_idx | input | 5 | Target register number |
| form | input | 2 | Addressing form: 0 displacement, 1 word-scaled, 2 quad-scaled, 3 indexed |
| upd | input | 1 | Update form: write the address back to the base register |
| imm | input | 16 | Raw immediate field |
| out_valid | output | 1 | Result present |
| ea | output | 64 | Effective address |
| wb_en | output | 1 | Write `wb_val` into the base register |
| wb_val | output | 64 | Value for the base register |
| bad_form | output | 1 | Update request had an invalid register combination |

## Verification
The only internal state is the output register, so any fault in the datapath shows as a wrong `ea` on the very next cycle. A bad base choice only shows for particular register numbers, and a bad scaling mask only shows for particular immediate bits. The sweep therefore crosses register number zero, equal base and target numbers, and immediates with their low bits set and their sign bit set. A control register stuck high or low shows as a `wb_en` or `bad_form` value that disagrees with the update flag one cycle after the request.

// File: rtl/lea_pkg.sv
package lea_pkg;
  typedef enum logic [1:0] {
    FORM_DISP  = 2'd0,
    FORM_WORD  = 2'd1,
    FORM_QUAD  = 2'd2,
    FORM_INDEX = 2'd3
  } lea_form_e;

  localparam int unsigned WORD_SCALE_BITS = 2;
  localparam int unsigned QUAD_SCALE_BITS = 4;
endpackage

// File: rtl/lea_offset.sv
module lea_offset
  import lea_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic [1:0]       form,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rb_val,
  output logic [XLEN-1:0]  off
);
  localparam int unsigned EXT_W = XLEN - IMM_W;
  localparam logic [IMM_W-1:0] WORD_MASK = ~IMM_W'((1 << WORD_SCALE_BITS) - 1);
  localparam logic [IMM_W-1:0] QUAD_MASK = ~IMM_W'((1 << QUAD_SCALE_BITS) - 1);

  logic [IMM_W-1:0] scaled;

  always_comb begin
    unique case (lea_form_e'(form))
      FORM_WORD: scaled = imm & WORD_MASK;
      FORM_QUAD: scaled = imm & QUAD_MASK;
      default:   scaled = imm;
    endcase
  end

  always_comb begin
    if (lea_form_e'(form) == FORM_INDEX) off = rb_val;
    else                                 off = {{EXT_W{scaled[IMM_W-1]}}, scaled};
  end
endmodule

// File: rtl/lea_base.sv
module lea_base #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic             upd,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [XLEN-1:0]  ra_val,
  output logic [XLEN-1:0]  base,
  output logic             bad
);
  logic ra_zero;

  always_comb begin
    ra_zero = (ra_idx == '0);
    base    = (upd || !ra_zero) ? ra_val : '0;
    bad     = upd && (ra_zero || (ra_idx == rt_idx));
  end
endmodule

// File: rtl/lea_add.sv
module lea_add #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum
);
  always_comb sum = a + b;
endmodule

// File: rtl/lea_gen.sv
module lea_gen #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned IMM_W   = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  rb_val,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [1:0]       form,
  input  logic             upd,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [XLEN-1:0]  ea,
  output logic             wb_en,
  output logic [XLEN-1:0]  wb_val,
  output logic             bad_form
);
  logic [XLEN-1:0] base_c, off_c, ea_c;
  logic            bad_c, wb_c, badv_c;

  lea_base #(.XLEN(XLEN), .IDX_W(IDX_W)) u_base (
    .upd(upd), .ra_idx(ra_idx), .rt_idx(rt_idx), .ra_val(ra_val),
    .base(base_c), .bad(bad_c)
  );

  lea_offset #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (
    .form(form), .imm(imm), .rb_val(rb_val), .off(off_c)
  );

  lea_add #(.XLEN(XLEN)) u_add (.a(base_c), .b(off_c), .sum(ea_c));

  always_comb begin
    badv_c = in_valid && bad_c;
    wb_c   = in_valid && upd && !bad_c;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic            vld_q, wb_q, bad_q, vld_d, wb_d, bad_d;
      logic [XLEN-1:0] ea_q, wbv_q, ea_d, wbv_d;

      always_comb begin
        vld_d = in_valid;
        wb_d  = wb_c;
        bad_d = badv_c;
        ea_d  = in_valid ? ea_c : ea_q;
        wbv_d = wb_c ? ea_c : wbv_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          wb_q  <= 1'b0;
          bad_q <= 1'b0;
        end else begin
          vld_q <= vld_d;
          wb_q  <= wb_d;
          bad_q <= bad_d;
        end
      end

      always_ff @(posedge clk) begin
        ea_q  <= ea_d;
        wbv_q <= wbv_d;
      end

      always_comb begin
        out_valid = vld_q;
        wb_en     = wb_q;
        bad_form  = bad_q;
        ea        = ea_q;
        wb_val    = wbv_q;
      end
    end else begin : g_comb
      always_comb begin
        out_valid = in_valid;
        wb_en     = wb_c;
        bad_form  = badv_c;
        ea        = ea_c;
        wb_val    = ea_c;
      end
    end
  endgenerate
endmodule

// File: rtl/lea_gen_chk.sv
module lea_gen_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned IMM_W   = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [XLEN-1:0]  rb_val,
  input logic [IDX_W-1:0] ra_idx,
  input logic [IDX_W-1:0] rt_idx,
  input logic [1:0]       form,
  input logic             upd,
  input logic             out_valid,
  input logic [XLEN-1:0]  ea,
  input logic             wb_en,
  input logic             bad_form
);
  a_r10_wb_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (out_valid && !bad_form));

  a_r10_bad_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> out_valid);

  if (OUT_REG) begin : g_seq
    a_r10_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    a_r8_ra_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && upd && ra_idx == '0) |=> (bad_form && !wb_en));

    a_r8_ra_eq_rt_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && upd && ra_idx == rt_idx) |=> (bad_form && !wb_en));

    a_r2_zero_base_index: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upd && ra_idx == '0 && form == 2'd3) |=> (ea == $past(rb_val)));
  end
endmodule

bind lea_gen lea_gen_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .IMM_W(IMM_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rb_val(rb_val),
  .ra_idx(ra_idx), .rt_idx(rt_idx), .form(form), .upd(upd),
  .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .bad_form(bad_form)
);

// File: tb/lea_gen_bench.sv
`timescale 1ns/1ps
module lea_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] ra_val, rb_val;
  logic [4:0]  ra_idx, rt_idx;
  logic [1:0]  form;
  logic        upd;
  logic [15:0] imm;
  logic        out_valid, wb_en, bad_form;
  logic [63:0] ea, wb_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  lea_gen u_lea_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ra_val(ra_val), .rb_val(rb_val),
    .ra_idx(ra_idx), .rt_idx(rt_idx), .form(form), .upd(upd), .imm(imm),
    .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .wb_val(wb_val), .bad_form(bad_form)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_off(input logic [1:0] f, input logic [15:0] im,
                                            input logic [63:0] rb);
    longint sv;
    sv = longint'($signed(im));
    case (f)
      2'd0: return 64'(sv);
      2'd1: return 64'((sv >>> 2) * 4);
      2'd2: return 64'((sv >>> 4) * 16);
      default: return rb;
    endcase
  endfunction

  task automatic run_one(input logic [1:0] f, input logic u, input logic [4:0] ri,
                         input logic [4:0] ti, input logic [15:0] im,
                         input logic [63:0] ra, input logic [63:0] rb);
    logic [63:0] exp_ea;
    logic        exp_bad;
    string       tag;
    @(negedge clk);
    in_valid = 1'b1; form = f; upd = u; ra_idx = ri; rt_idx = ti; imm = im;
    ra_val = ra; rb_val = rb;
    exp_ea  = ((u || ri != 0) ? ra : 64'd0) + model_off(f, im, rb);
    exp_bad = u && (ri == 0 || ri == ti);
    case (f)
      2'd0: tag = "R3";
      2'd1: tag = "R4";
      2'd2: tag = "R5";
      default: tag = "R6";
    endcase
    if (!u && ri == 0) tag = {tag, "/R2"};
    if (u) tag = {tag, "/R7"};
    @(negedge clk);
    chk("R10 out_valid", {63'd0, out_valid}, 64'd1);
    chk({tag, " ea"}, ea, exp_ea);
    chk("R8 bad_form", {63'd0, bad_form}, {63'd0, exp_bad});
    chk("R7/R8 wb_en", {63'd0, wb_en}, {63'd0, u && !exp_bad});
    if (u && !exp_bad) chk("R7 wb_val", wb_val, exp_ea);
  endtask

  initial begin
    logic [4:0]  ra_set [4] = '{5'd0, 5'd1, 5'd5, 5'd31};
    logic [4:0]  rt_set [3] = '{5'd0, 5'd5, 5'd31};
    logic [15:0] im_set [8] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000,
                                16'hffff, 16'h1234, 16'hfffc, 16'h0013};
    int k = 0;
    rst_n = 1'b0; in_valid = 1'b0; ra_val = '0; rb_val = '0;
    ra_idx = '0; rt_idx = '0; form = '0; upd = 1'b0; imm = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R1 wb_en in reset", {63'd0, wb_en}, 64'd0);
    chk("R1 bad_form in reset", {63'd0, bad_form}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", {63'd0, out_valid}, 64'd0);
    chk("R10 idle wb_en", {63'd0, wb_en}, 64'd0);

    for (int f = 0; f < 4; f++)
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 4; a++)
          for (int t = 0; t < 3; t++)
            for (int i = 0; i < 8; i++) begin
              k++;
              run_one(2'(f), 1'(u), ra_set[a], rt_set[t], im_set[i],
                      64'h0123_4567_89ab_cdef * 64'(k) + 64'h10,
                      64'hfedc_ba98_7654_3210 ^ (64'(k) << 7));
            end

    run_one(2'd3, 1'b0, 5'd3, 5'd4, 16'hffff, 64'hffff_ffff_ffff_fff0, 64'h20); // R9 wrap
    chk("R9 wrap", ea, 64'h10);
    run_one(2'd0, 1'b0, 5'd3, 5'd4, 16'h8000, 64'h0000_0000_0000_4000, 64'h0); // R9 below zero
    chk("R9 negative wrap", ea, 64'hffff_ffff_ffff_c000);
    run_one(2'd3, 1'b0, 5'd2, 5'd4, 16'h0000, 64'h100, 64'h5);
    run_one(2'd3, 1'b0, 5'd2, 5'd4, 16'h8abc, 64'h100, 64'h5); // R6 imm ignored
    chk("R6 imm ignored", ea, 64'h105);

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R10 idle bad_form", {63'd0, bad_form}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule